// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block takes a starting column and burst settings in mode-register form. It then produces one column address for each beat of a read or write burst. A burst starts through a valid/ready handshake. The beat addresses leave on a valid/ready output stream, which lets a downstream command or data stage slow the burst down.

The block supports two beat orderings. The sequential order adds the beat count to the low bits of the start column. The interleaved order XORs the beat count into the low bits of the start column. Fixed bursts of 1, 2, 4 or 8 beats mark their final beat. A full-page burst walks the whole column space with wraparound and runs until a stop input ends it. For read bursts, a data-output enable is held for the length of the burst and is dropped once the burst ends, which releases the data bus.

Command decoding, the CAS-latency data pipeline and the memory array belong to other blocks.

Top module: `sdram_burst_colgen`

## Requirements
- R1: A start request is taken on a clock edge where `start_valid` and `start_ready` are both high. `start_ready` is high only when no burst is running. The first beat appears on `addr_*` in the cycle after the request is taken.
- R2: While `addr_valid` is high and `addr_ready` is low, `addr_col` and `addr_last` hold their values. A beat advances only on a cycle where `addr_valid` and `addr_ready` are both high.
- R3: The three-bit length code `cfg_len` selects the burst length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives a full page of 2**COL_W columns (256 by default).
- R4: With `cfg_wrap`=0 (sequential), beat i of a burst of length BL has low log2(BL) bits equal to (start+i) mod BL. The upper bits equal the start column.
- R5: With `cfg_wrap`=1 (interleaved) and a fixed length, beat i has low log2(BL) bits equal to start XOR i. The upper bits equal the start column.
- R6: `addr_last` is high on the final beat of a fixed-length burst and on no other beat. After that beat is transferred, `addr_valid` is low in the next cycle.
- R7: A full-page burst steps through the columns by +1 and wraps from the top column to 0. It never raises `addr_last` and keeps going past 2**COL_W beats.
- R8: If `stop` is high on a clock edge during a burst of any length, the burst ends at that edge and `addr_valid` is low in the next cycle.
- R9: A full-page code together with `cfg_wrap`=1 sets `cfg_err` and runs the burst in sequential order. `cfg_err` shows the result for the most recently taken request and is cleared by a legal one.
- R10: Length codes 3'b100, 3'b101 and 3'b110 are reserved. They set `cfg_err`, produce no beats, and `start_ready` is high again in the next cycle.
- R11: For a read request (`start_rd`=1), `dq_oe` is high on every beat of the burst and low in the cycle after the burst ends. It stays low for write bursts.
- R12: After reset, `start_ready`=1 and `addr_valid`, `addr_last`, `dq_oe` and `cfg_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Start request valid |
| start_ready | output | 1 | Block idle, request can be taken |
| start_col | input | COL_W | Starting column address |
| start_rd | input | 1 | 1 = read burst, 0 = write burst |
| cfg_wrap | input | 1 | Ordering: 0 sequential, 1 interleaved |
| cfg_len | input | 3 | Burst length code |
| stop | input | 1 | Ends the running burst |
| addr_valid | output | 1 | Beat address valid |
| addr_ready | input | 1 | Downstream takes the beat |
| addr_col | output | COL_W | Column address of the current beat |
| addr_last | output | 1 | Final beat of a fixed-length burst |
| dq_oe | output | 1 | Data-output enable for read bursts |
| cfg_err | output | 1 | Illegal configuration on the last taken request |

## Verification
Beat 0 is due one cycle after the start handshake edge. Each later beat is due one cycle after the edge that transferred the previous beat. The end of the burst, whether by the final transfer or by `stop`, shows as `addr_valid` and `dq_oe` low one cycle after that edge. `cfg_err` changes at the handshake edge. The bench drives all inputs and samples all outputs on the falling edge, so each expected value is compared half a cycle after the rising edge that produced it. The expected addresses come from a formula taken from the ordering rules.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int LOG_W = 4;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  typedef struct packed {
    logic             legal;    // length code is not reserved
    logic             full;     // full-page burst
    logic             ilv;      // effective interleaved order
    logic             err;      // configuration error flag
    logic [LOG_W-1:0] len_log;  // log2 of the burst length
  } burst_cfg_t;
endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic       wrap,
  input  logic [2:0] code,
  output burst_cfg_t cfg
);
  always_comb begin
    cfg = '0;
    cfg.legal = 1'b1;
    unique case (code)
      LEN_1:    cfg.len_log = LOG_W'(0);
      LEN_2:    cfg.len_log = LOG_W'(1);
      LEN_4:    cfg.len_log = LOG_W'(2);
      LEN_8:    cfg.len_log = LOG_W'(3);
      LEN_PAGE: begin
        cfg.len_log = LOG_W'(COL_W);
        cfg.full    = 1'b1;
      end
      default: begin
        cfg.legal = 1'b0;
        cfg.err   = 1'b1;
      end
    endcase
    // interleave is only legal for fixed lengths; fall back to sequential
    cfg.ilv = wrap & ~cfg.full;
    if (wrap && cfg.full) cfg.err = 1'b1;
  end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             ready,
  input  logic             stop,
  input  logic             full,
  input  logic [COL_W-1:0] mask,
  output logic             busy,
  output logic             last,
  output logic [COL_W-1:0] cnt
);
  logic busy_q;
  logic [COL_W-1:0] cnt_q;
  logic fire;

  assign fire = busy_q & ready;
  assign last = busy_q & ~full & (cnt_q == mask);
  assign busy = busy_q;
  assign cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (stop || (fire && last)) begin
        busy_q <= 1'b0;
      end else if (fire) begin
        cnt_q <= cnt_q + COL_W'(1);
      end
    end
  end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] cnt,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] sum;
  assign sum = start + cnt;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign addr[b] = mask[b] ? (ilv ? (start[b] ^ cnt[b]) : sum[b]) : start[b];
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_rd,
  input  logic             cfg_wrap,
  input  logic [2:0]       cfg_len,
  input  logic             stop,
  output logic             addr_valid,
  input  logic             addr_ready,
  output logic [COL_W-1:0] addr_col,
  output logic             addr_last,
  output logic             dq_oe,
  output logic             cfg_err
);
  burst_cfg_t       dec;
  burst_cfg_t       cfg_q;
  logic [COL_W-1:0] start_q;
  logic             rd_q;
  logic             err_q;
  logic             busy;
  logic             last;
  logic             accept;
  logic [COL_W-1:0] cnt;
  logic [COL_W:0]   one_sh;
  logic [COL_W-1:0] mask;

  burst_mode_decode #(.COL_W(COL_W)) u_dec (
    .wrap (cfg_wrap),
    .code (cfg_len),
    .cfg  (dec)
  );

  assign accept = start_valid & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      start_q <= '0;
      rd_q    <= 1'b0;
      err_q   <= 1'b0;
    end else if (accept) begin
      cfg_q   <= dec;
      start_q <= start_col;
      rd_q    <= start_rd;
      err_q   <= dec.err;
    end
  end

  assign one_sh = (COL_W + 1)'(1) << cfg_q.len_log;
  assign mask   = one_sh[COL_W-1:0] - COL_W'(1);

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (accept & dec.legal),
    .ready (addr_ready),
    .stop  (stop),
    .full  (cfg_q.full),
    .mask  (mask),
    .busy  (busy),
    .last  (last),
    .cnt   (cnt)
  );

  burst_addr_calc #(.COL_W(COL_W)) u_addr (
    .start (start_q),
    .cnt   (cnt),
    .mask  (mask),
    .ilv   (cfg_q.ilv),
    .addr  (addr_col)
  );

  assign start_ready = ~busy;
  assign addr_valid  = busy;
  assign addr_last   = last;
  assign dq_oe       = busy & rd_q;
  assign cfg_err     = err_q;
endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_valid,
  input logic             start_ready,
  input logic             stop,
  input logic             addr_valid,
  input logic             addr_ready,
  input logic [COL_W-1:0] addr_col,
  input logic             addr_last,
  input logic             dq_oe,
  input logic             cfg_err
);
  // R1
  start_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_valid) |-> $past(start_valid && start_ready));

  // R2
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready && !stop |=> addr_valid && $stable(addr_col) && $stable(addr_last));

  // R6
  end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr_ready && addr_last |=> !addr_valid);

  // R8
  burst_end_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_valid) |-> $past(stop || (addr_ready && addr_last)));

  // R11
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> !addr_valid);

  // R9
  err_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && $past(addr_valid) |-> $stable(cfg_err));
endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .stop        (stop),
  .addr_valid  (addr_valid),
  .addr_ready  (addr_ready),
  .addr_col    (addr_col),
  .addr_last   (addr_last),
  .dq_oe       (dq_oe),
  .cfg_err     (cfg_err)
);

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;
  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_valid = 1'b0;
  logic             start_ready;
  logic [COL_W-1:0] start_col = '0;
  logic             start_rd = 1'b0;
  logic             cfg_wrap = 1'b0;
  logic [2:0]       cfg_len = 3'b000;
  logic             stop = 1'b0;
  logic             addr_valid;
  logic             addr_ready = 1'b1;
  logic [COL_W-1:0] addr_col;
  logic             addr_last;
  logic             dq_oe;
  logic             cfg_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_col(start_col), .start_rd(start_rd), .cfg_wrap(cfg_wrap), .cfg_len(cfg_len),
    .stop(stop), .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_col(addr_col),
    .addr_last(addr_last), .dq_oe(dq_oe), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s, input int i,
                                                input int lg, input bit ilv);
    logic [COL_W-1:0] m;
    logic [COL_W-1:0] lo;
    m  = COL_W'((1 << lg) - 1);
    lo = ilv ? ((s ^ COL_W'(i)) & m) : ((s + COL_W'(i)) & m);
    return (s & ~m) | lo;
  endfunction

  task automatic do_start(input logic [COL_W-1:0] col, input logic [2:0] code,
                          input bit wrap, input bit rd);
    @(negedge clk);
    start_valid = 1'b1; start_col = col; cfg_len = code; cfg_wrap = wrap; start_rd = rd;
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  // Checks n beats at consecutive falling edges, addr_ready held high.
  task automatic run_beats(input logic [COL_W-1:0] s, input int n, input int lg, input bit ilv,
                           input bit fixed, input bit rd, input string req);
    for (int i = 0; i < n; i++) begin
      chk(addr_valid === 1'b1, req, "addr_valid", int'(addr_valid), 1);
      chk(addr_col === exp_col(s, i, lg, ilv), req, "addr_col", int'(addr_col), int'(exp_col(s, i, lg, ilv)));
      chk(addr_last === (fixed && i == n - 1), "R6", "addr_last", int'(addr_last), int'(fixed && i == n - 1));
      chk(dq_oe === rd, "R11", "dq_oe in burst", int'(dq_oe), int'(rd));
      if (!fixed || i != n - 1) @(negedge clk);
    end
    if (fixed) begin
      @(negedge clk);
      chk(addr_valid === 1'b0, "R6", "valid after last", int'(addr_valid), 0);
      chk(dq_oe === 1'b0, "R11", "dq_oe after burst", int'(dq_oe), 0);
      chk(start_ready === 1'b1, "R1", "ready after burst", int'(start_ready), 1);
    end
  endtask

  task automatic stop_now();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(addr_valid === 1'b0, "R8", "valid after stop", int'(addr_valid), 0);
    chk(dq_oe === 1'b0, "R11", "dq_oe after stop", int'(dq_oe), 0);
    chk(start_ready === 1'b1, "R8", "ready after stop", int'(start_ready), 1);
  endtask

  task automatic t_reset();
    chk(start_ready === 1'b1, "R12", "start_ready", int'(start_ready), 1);
    chk(addr_valid === 1'b0, "R12", "addr_valid", int'(addr_valid), 0);
    chk(addr_last === 1'b0, "R12", "addr_last", int'(addr_last), 0);
    chk(dq_oe === 1'b0, "R12", "dq_oe", int'(dq_oe), 0);
    chk(cfg_err === 1'b0, "R12", "cfg_err", int'(cfg_err), 0);
  endtask

  task automatic t_seq4_read();   // R4 R3 R11: 2D,2E,2F,2C
    do_start(8'h2D, 3'b010, 1'b0, 1'b1);
    chk(start_ready === 1'b0, "R1", "busy ready", int'(start_ready), 0);
    run_beats(8'h2D, 4, 2, 1'b0, 1'b1, 1'b1, "R4");
  endtask

  task automatic t_ilv8();        // R5: 35,34,37,36,31,30,33,32
    do_start(8'h35, 3'b011, 1'b1, 1'b1);
    chk(cfg_err === 1'b0, "R9", "cfg_err legal", int'(cfg_err), 0);
    run_beats(8'h35, 8, 3, 1'b1, 1'b1, 1'b1, "R5");
  endtask

  task automatic t_short();       // R3: lengths 1 and 2
    do_start(8'h7A, 3'b000, 1'b0, 1'b0);
    run_beats(8'h7A, 1, 0, 1'b0, 1'b1, 1'b0, "R3");
    do_start(8'h41, 3'b001, 1'b1, 1'b0);
    run_beats(8'h41, 2, 1, 1'b1, 1'b1, 1'b0, "R3");
  endtask

  task automatic t_full_page();   // R7 R8: 300 beats from FE, wraps, then stop
    do_start(8'hFE, 3'b111, 1'b0, 1'b1);
    run_beats(8'hFE, 300, COL_W, 1'b0, 1'b0, 1'b1, "R7");
    chk(addr_valid === 1'b1, "R7", "still running", int'(addr_valid), 1);
    stop_now();
  endtask

  task automatic t_full_ilv();    // R9: flagged, sequential order
    do_start(8'h05, 3'b111, 1'b1, 1'b0);
    chk(cfg_err === 1'b1, "R9", "cfg_err page+ilv", int'(cfg_err), 1);
    run_beats(8'h05, 6, COL_W, 1'b0, 1'b0, 1'b0, "R9");
    stop_now();
  endtask

  task automatic t_reserved();    // R10
    do_start(8'h10, 3'b101, 1'b0, 1'b1);
    chk(cfg_err === 1'b1, "R10", "cfg_err reserved", int'(cfg_err), 1);
    chk(addr_valid === 1'b0, "R10", "no beats", int'(addr_valid), 0);
    chk(start_ready === 1'b1, "R10", "ready again", int'(start_ready), 1);
    @(negedge clk);
    chk(addr_valid === 1'b0, "R10", "still no beats", int'(addr_valid), 0);
    do_start(8'h20, 3'b000, 1'b0, 1'b0);
    chk(cfg_err === 1'b0, "R9", "cfg_err cleared", int'(cfg_err), 0);
    run_beats(8'h20, 1, 0, 1'b0, 1'b1, 1'b0, "R3");
  endtask

  task automatic t_backpressure(); // R2, write keeps dq_oe low
    addr_ready = 1'b0;
    do_start(8'h13, 3'b011, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      chk(addr_valid === 1'b1, "R2", "valid held", int'(addr_valid), 1);
      chk(addr_col === 8'h13, "R2", "col held", int'(addr_col), 8'h13);
      chk(dq_oe === 1'b0, "R11", "write dq_oe", int'(dq_oe), 0);
      @(negedge clk);
    end
    addr_ready = 1'b1;
    run_beats(8'h13, 8, 3, 1'b0, 1'b1, 1'b0, "R2");
  endtask

  task automatic t_stop_fixed();  // R8 on a fixed burst
    do_start(8'hC6, 3'b011, 1'b1, 1'b1);
    run_beats(8'hC6, 3, 3, 1'b1, 1'b0, 1'b1, "R5");
    stop_now();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seq4_read();
    t_ilv8();
    t_short();
    t_full_page();
    t_full_ilv();
    t_reserved();
    t_backpressure();
    t_stop_fixed();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule